// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block produces the address bytes an I2C master must put on the bus after a START, in either 7-bit or 10-bit addressing. A requester places a target address, a direction and two mode bits on the configuration inputs and pulses a start request. The block captures those settings and then offers one address byte at a time to a byte-level bus engine. Each byte carries markers that tell the engine whether a START or a repeated START has to come before it. The engine returns one completion pulse per byte, together with the acknowledge result.

A 10-bit read is sent in full by default: the header in write direction, then the low address byte, then a repeated START, then the header again in read direction. A header-only option shortens a 10-bit read to the single read header. When the last byte is acknowledged, the block raises a done pulse. A not-acknowledge on any byte ends the sequence at once, sets a sticky NACK flag and pulses a STOP request.

Top module: `i2c_addr_seq`

## Requirements
- R1: With ten-bit mode off, exactly one byte is sent. It is {addr[7:1], rd}, with rd in bit 0. Address bits 9, 8 and 0 have no effect on it.
- R2: A 10-bit write sends two bytes: the header {5'b11110, addr[9], addr[8], 1'b0}, then addr[7:0].
- R3: A 10-bit read with header-only off sends three bytes: the header with bit 0 = 0, then addr[7:0], then the header with bit 0 = 1. tx_restart is 1 on the third byte only.
- R4: A 10-bit read with header-only on sends one byte, {5'b11110, addr[9], addr[8], 1'b1}. Header-only has no effect on 10-bit writes or on 7-bit mode.
- R5: tx_first is 1 while the first byte of a sequence is offered and 0 otherwise. tx_restart is 0 except on the read header that follows the low byte.
- R6: start_req is accepted only while busy is low. busy and tx_valid go high in the cycle after acceptance, and tx_valid is never high while busy is low.
- R7: The configuration is captured when a request is accepted. Configuration changes while busy, and start_req pulses while busy, have no effect on the bytes sent.
- R8: When tx_done arrives with tx_nack = 0 on the last byte, done pulses for exactly one cycle in the following cycle, and busy falls in that same cycle.
- R9: When tx_done arrives with tx_nack = 1 on any byte, the next cycle shows busy low, nack_flag high and a one-cycle stop_req pulse. nack_flag stays high until the next request is accepted.
- R10: A tx_done pulse while tx_valid is low has no effect.
- R11: While reset is asserted and after it is released, all outputs are 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 10 | Target address field |
| cfg_rd | input | 1 | Direction: 0 = write, 1 = read |
| cfg_ten | input | 1 | 10-bit addressing when 1 |
| cfg_hdr_only | input | 1 | Send only the read header for 10-bit reads |
| start_req | input | 1 | Request a new address phase |
| tx_done | input | 1 | Engine finished the offered byte |
| tx_nack | input | 1 | Byte was not acknowledged (valid with tx_done) |
| tx_valid | output | 1 | A byte is offered to the engine |
| tx_byte | output | 8 | Offered address byte |
| tx_first | output | 1 | Engine must issue START before this byte |
| tx_restart | output | 1 | Engine must issue repeated START before this byte |
| busy | output | 1 | Address phase in progress |
| done | output | 1 | One-cycle pulse: all address bytes acknowledged |
| nack_flag | output | 1 | Sticky: the last sequence was aborted by NACK |
| stop_req | output | 1 | One-cycle pulse asking the engine for a STOP |

## Verification
An accepted start_req shows up as busy, tx_valid and the first byte one clock edge later. Each tx_done moves the offered byte, or lowers busy while pulsing done or stop_req, one edge later. The bench keeps a reference model that advances on the same rising edge from the inputs held at that edge. The model builds the expected byte queue from the requirements when a request is accepted, and every output is compared with it on every falling edge. Inputs change just after falling edges, so each comparison falls exactly one edge after the stimulus that caused it.

// File: rtl/i2c_addr_seq_pkg.sv
package i2c_addr_seq_pkg;

    localparam int ADDR_W   = 10;
    localparam int BYTE_W   = 8;
    localparam int MAX_SEQ  = 3;
    localparam int STEP_W   = $clog2(MAX_SEQ + 1);
    localparam logic [4:0] HDR_MARK = 5'b11110;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              ten;
        logic              hdr_only;
    } seq_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              restart;
    } addr_byte_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_t;

    function automatic logic [BYTE_W-1:0] hdr_byte(logic [ADDR_W-1:0] a, logic dir);
        return {HDR_MARK, a[9], a[8], dir};
    endfunction

    function automatic logic [STEP_W-1:0] seq_len(seq_cfg_t c);
        if (!c.ten)             return STEP_W'(1);
        else if (!c.rd)         return STEP_W'(2);
        else if (c.hdr_only)    return STEP_W'(1);
        else                    return STEP_W'(3);
    endfunction

endpackage

// File: rtl/i2c_addr_fmt.sv
module i2c_addr_fmt
    import i2c_addr_seq_pkg::*;
(
    input  seq_cfg_t          cfg,
    input  logic [STEP_W-1:0] step,
    output addr_byte_t        abyte,
    output logic              last
);
    logic [STEP_W-1:0] len;

    always_comb begin
        len           = seq_len(cfg);
        last          = (step == len - STEP_W'(1));
        abyte.restart = 1'b0;
        abyte.data    = '0;
        if (!cfg.ten) begin
            abyte.data = {cfg.addr[7:1], cfg.rd};
        end else if (cfg.rd && cfg.hdr_only) begin
            abyte.data = hdr_byte(cfg.addr, 1'b1);
        end else begin
            case (step)
                STEP_W'(0): abyte.data = hdr_byte(cfg.addr, 1'b0);
                STEP_W'(1): abyte.data = cfg.addr[7:0];
                default: begin
                    abyte.data    = hdr_byte(cfg.addr, 1'b1);
                    abyte.restart = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
    import i2c_addr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_cfg_t          cfg_in,
    input  logic              start_req,
    input  logic              tx_done,
    input  logic              tx_nack,
    input  logic              last,
    output seq_cfg_t          cfg_q,
    output logic [STEP_W-1:0] step,
    output logic              busy,
    output logic              done,
    output logic              nack_flag,
    output logic              stop_req
);
    seq_state_t state;

    assign busy = (state == ST_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '0;
            step      <= '0;
            done      <= 1'b0;
            nack_flag <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            done     <= 1'b0;
            stop_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state     <= ST_SEND;
                        cfg_q     <= cfg_in;
                        step      <= '0;
                        nack_flag <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (tx_done) begin
                        if (tx_nack) begin
                            state     <= ST_IDLE;
                            nack_flag <= 1'b1;
                            stop_req  <= 1'b1;
                        end else if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && $past(tx_done) && !$past(tx_nack)));

    // R9
    stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

    // R9
    stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (nack_flag && !busy));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && tx_done && !start_req) |=> (!busy && !done && !stop_req));
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
    import i2c_addr_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_rd,
    input  logic                 cfg_ten,
    input  logic                 cfg_hdr_only,
    input  logic                 start_req,
    input  logic                 tx_done,
    input  logic                 tx_nack,
    output logic                 tx_valid,
    output logic [BYTE_W-1:0]    tx_byte,
    output logic                 tx_first,
    output logic                 tx_restart,
    output logic                 busy,
    output logic                 done,
    output logic                 nack_flag,
    output logic                 stop_req
);
    seq_cfg_t          cfg_in;
    seq_cfg_t          cfg_q;
    logic [STEP_W-1:0] step;
    addr_byte_t        abyte;
    logic              last;

    assign cfg_in = '{addr: cfg_addr, rd: cfg_rd, ten: cfg_ten, hdr_only: cfg_hdr_only};

    i2c_addr_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .start_req (start_req),
        .tx_done   (tx_done),
        .tx_nack   (tx_nack),
        .last      (last),
        .cfg_q     (cfg_q),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .nack_flag (nack_flag),
        .stop_req  (stop_req)
    );

    i2c_addr_fmt fmt_i (
        .cfg   (cfg_q),
        .step  (step),
        .abyte (abyte),
        .last  (last)
    );

    assign tx_valid   = busy;
    assign tx_byte    = busy ? abyte.data : '0;
    assign tx_first   = busy && (step == '0);
    assign tx_restart = busy && abyte.restart;

    // R5
    restart_pos_chk: assert property (@(posedge clk) disable iff (rst)
        tx_restart |-> (tx_valid && !tx_first && cfg_q.ten && cfg_q.rd));

    // R6
    valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_valid);

    // R6
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req) |=> (busy && tx_first));

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/i2c_addr_seq_tb.sv
`timescale 1ns/1ps
module i2c_addr_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] cfg_addr = '0;
    logic       cfg_rd = 1'b0, cfg_ten = 1'b0, cfg_hdr_only = 1'b0;
    logic       start_req = 1'b0, tx_done = 1'b0, tx_nack = 1'b0;
    logic       tx_valid, tx_first, tx_restart, busy, done, nack_flag, stop_req;
    logic [7:0] tx_byte;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    i2c_addr_seq dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd),
        .cfg_ten(cfg_ten), .cfg_hdr_only(cfg_hdr_only), .start_req(start_req),
        .tx_done(tx_done), .tx_nack(tx_nack), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_first(tx_first), .tx_restart(tx_restart),
        .busy(busy), .done(done), .nack_flag(nack_flag), .stop_req(stop_req)
    );

    // reference model state
    logic [8:0] m_q[$];
    bit  m_busy = 0, m_done = 0, m_stop = 0, m_nack = 0;
    int  m_idx = 0;
    string m_tag = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        m_done = 0; m_stop = 0;
        if (rst) begin
            m_busy = 0; m_nack = 0; m_q.delete(); m_idx = 0;
        end else if (!m_busy && start_req) begin
            logic [7:0] h0, h1;
            h0 = {5'b11110, cfg_addr[9:8], 1'b0};
            h1 = {5'b11110, cfg_addr[9:8], 1'b1};
            m_busy = 1; m_nack = 0; m_idx = 0; m_q.delete();
            if (!cfg_ten) begin
                m_q.push_back({1'b0, cfg_addr[7:1], cfg_rd}); m_tag = "R1";
            end else if (!cfg_rd) begin
                m_q.push_back({1'b0, h0}); m_q.push_back({1'b0, cfg_addr[7:0]}); m_tag = "R2";
            end else if (cfg_hdr_only) begin
                m_q.push_back({1'b0, h1}); m_tag = "R4";
            end else begin
                m_q.push_back({1'b0, h0}); m_q.push_back({1'b0, cfg_addr[7:0]});
                m_q.push_back({1'b1, h1}); m_tag = "R3";
            end
        end else if (m_busy && tx_done) begin
            if (tx_nack) begin
                m_busy = 0; m_nack = 1; m_stop = 1; m_q.delete();
            end else begin
                void'(m_q.pop_front()); m_idx++;
                if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        logic [8:0] e;
        e = (m_busy && m_q.size() > 0) ? m_q[0] : 9'h0;
        chk("R6", "busy", busy, m_busy);
        chk("R6", "tx_valid", tx_valid, m_busy);
        chk(m_tag, "tx_byte", tx_byte, e[7:0]);
        chk("R5", "tx_first", tx_first, m_busy && m_idx == 0);
        chk("R5", "tx_restart", tx_restart, e[8]);
        chk("R8", "done", done, m_done);
        chk("R9", "stop_req", stop_req, m_stop);
        chk("R9", "nack_flag", nack_flag, m_nack);
    end

    task automatic xfer(input logic [9:0] a, input bit rd, ten, hdr,
                        input int nack_at, input int gap, input bit mutate);
        @(negedge clk); #1;
        cfg_addr = a; cfg_rd = rd; cfg_ten = ten; cfg_hdr_only = hdr; start_req = 1;
        @(negedge clk); #1;
        start_req = 0;
        if (mutate) begin
            // R7: new settings and a second request while busy must be ignored
            cfg_addr = ~a; cfg_rd = ~rd; cfg_hdr_only = ~hdr; start_req = 1;
            @(negedge clk); #1;
            start_req = 0;
        end
        for (int i = 0; i < 6; i++) begin
            repeat (gap) @(negedge clk);
            if (!tx_valid) break;
            #1; tx_done = 1; tx_nack = (i == nack_at);
            @(negedge clk); #1;
            tx_done = 0; tx_nack = 0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs low in reset
        chk("R11", "outputs in reset", {tx_valid, tx_byte, busy, done, nack_flag, stop_req}, 0);
        #1; rst = 0;
        @(negedge clk);
        chk("R11", "outputs after reset", {tx_valid, tx_byte, busy, done, nack_flag, stop_req}, 0);

        xfer(10'h355, 1'b0, 1'b0, 1'b0, -1, 1, 0);   // R1 write, bits 9,8,0 set
        xfer(10'h0AA, 1'b1, 1'b0, 1'b1, -1, 2, 0);   // R1 read, R4 hdr-only ignored in 7-bit
        xfer(10'h2C3, 1'b0, 1'b1, 1'b0, -1, 1, 0);   // R2
        xfer(10'h2C3, 1'b0, 1'b1, 1'b1, -1, 1, 0);   // R4 hdr-only ignored for writes
        xfer(10'h1F0, 1'b1, 1'b1, 1'b0, -1, 3, 0);   // R3
        xfer(10'h3FF, 1'b1, 1'b1, 1'b1, -1, 1, 0);   // R4
        xfer(10'h15A, 1'b1, 1'b1, 1'b0, -1, 1, 1);   // R7
        xfer(10'h155, 1'b1, 1'b1, 1'b0, 1, 1, 0);    // R9 NACK on second byte
        chk("R9", "nack_flag sticky", nack_flag, 1);
        xfer(10'h0F0, 1'b1, 1'b1, 1'b0, 2, 1, 0);    // R9 NACK on read header
        xfer(10'h012, 1'b0, 1'b0, 1'b0, 0, 1, 0);    // R9 NACK on 7-bit byte

        // R10: stray tx_done while idle
        @(negedge clk); #1; tx_done = 1;
        @(negedge clk); #1; tx_done = 0;
        @(negedge clk);
        chk("R10", "stray tx_done state", {busy, done, stop_req, nack_flag}, 4'b0001);

        xfer(10'h2A5, 1'b0, 1'b1, 1'b0, -1, 1, 0);   // R9 flag cleared by new request
        chk("R9", "nack_flag cleared", nack_flag, 0);
        // R6: back-to-back requests
        xfer(10'h07E, 1'b0, 1'b0, 1'b0, -1, 1, 0);
        xfer(10'h300, 1'b1, 1'b1, 1'b0, -1, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule